// File: doc/BRIEF.md
# Miss-merging fill buffer

This block keeps track of data-cache misses that are waiting on the next cache level. It sits between the first-level lookup and the single request port of the second level. Each access that misses the first level arrives with a byte address and a requester tag. The block compares the line part of the address against every live entry.

If no entry holds that line, the block claims a free entry and later sends exactly one line request downstream. If an entry already holds the line, the new requester is appended to that entry's tag list, and no further downstream request is made. When the line comes back, the block answers every requester recorded in the entry, one per cycle and in the order they arrived, and then releases the entry.

Store hits under a write-through policy share the same downstream port and are forwarded through it. Line requests win any conflict with them. Three event counters let software-visible profiling see the following:

- first-level misses
- downstream accesses
- misses that were merged away

As a result, the first two counts can differ by a large factor.

Top module: `miss_merge_buf`

## Requirements
- R1: Two misses target the same line when their addresses agree in every bit above the line offset (bits [5:0] for the default 64-byte line). A line request presents the line address with the offset bits zero.
- R2: A miss whose line matches no waiting or outstanding entry is accepted into the lowest-numbered free entry, and `miss_idx` reports that entry. Line requests are offered with `l2_req_is_st`=0 and `l2_req_id` equal to the entry index. When several entries are waiting, the lowest-numbered one is offered first. An entry moves to outstanding on the cycle its request meets `l2_req_ready`.
- R3: A miss whose line matches a waiting or outstanding entry is merged into that entry, and `miss_idx` reports it. A merge never causes a second line request for that line.
- R4: The L1-miss counter counts every accepted miss. The squash counter counts every accepted merge. The L2-access counter counts every cycle with `l2_req_valid` and `l2_req_ready` both high. So 64 byte-wise misses over one aligned line give 64, 63 and 1.
- R5: `miss_ready` is low in three cases: when `cancel_valid` is high, when the matched entry already holds MRG_DEPTH tags, or when there is no match and no free entry.
- R6: A fill whose `fill_idx` names an outstanding entry starts a drain. From the next cycle the entry emits one response per cycle (`rsp_valid`, `rsp_tag`, `rsp_idx`) in arrival order, and it becomes free after the last one. When several entries drain, the lowest-numbered one responds first. A fill naming an entry that is not outstanding has no effect.
- R7: A miss accepted in the same cycle as the fill for its line is merged and answered as part of that fill's drain.
- R8: A write-through store is offered downstream with `l2_req_is_st`=1 and its own address and data only when no entry is waiting. `st_ready` is high exactly when it is offered and `l2_req_ready` is high.
- R9: A cancel naming a waiting entry frees it, and no line request is made for it. A cancel is ignored when the named entry is outstanding, draining or free, or when its request is accepted in the same cycle.
- R10: The counters are CNT_W bits wide and stop at all-ones. `cnt_clear` zeroes all three on the next edge and takes precedence over any increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| miss_valid | input | 1 | A first-level miss is presented |
| miss_ready | output | 1 | The presented miss is accepted this cycle |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_tag | input | TAG_W | Requester tag returned in the response |
| miss_idx | output | IDX_W | Entry that takes the presented miss |
| cancel_valid | input | 1 | Withdraw a speculative miss that is not yet requested |
| cancel_idx | input | IDX_W | Entry to withdraw |
| st_valid | input | 1 | Write-through store hit to forward |
| st_ready | output | 1 | Store forwarded this cycle |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| l2_req_valid | output | 1 | Downstream request offered |
| l2_req_ready | input | 1 | Downstream accepts the request |
| l2_req_is_st | output | 1 | 1 for a forwarded store, 0 for a line request |
| l2_req_addr | output | ADDR_W | Request address |
| l2_req_data | output | DATA_W | Store data, zero for a line request |
| l2_req_id | output | IDX_W | Entry index of a line request, zero for a store |
| fill_valid | input | 1 | Downstream returns a line |
| fill_idx | input | IDX_W | Entry the returned line belongs to |
| rsp_valid | output | 1 | A requester is answered |
| rsp_tag | output | TAG_W | Tag of the answered requester |
| rsp_idx | output | IDX_W | Entry the response comes from |
| cnt_clear | input | 1 | Synchronous clear of all counters |
| cnt_l1_miss | output | CNT_W | Accepted misses |
| cnt_l2_acc | output | CNT_W | Downstream accesses |
| cnt_squash | output | CNT_W | Merged misses |

## Verification
The bench builds the block with four entries and a merge depth of 64. At that depth a whole 64-byte line of byte-wise misses collapses into one entry, and a 65th same-line miss meets back-pressure. The counters are narrowed to 7 bits, so random traffic drives all three into saturation and then clears them within a few thousand cycles. A 16-bit address keeps line numbers easy to pick while still placing neighbouring lines one offset apart, which exercises the line boundary.

// File: rtl/mmb_pkg.sv
package mmb_pkg;
   // Life cycle of one fill-buffer entry
   typedef enum logic [1:0] {
      ENT_FREE  = 2'd0,
      ENT_WAIT  = 2'd1,   // allocated, line request not yet accepted
      ENT_OUT   = 2'd2,   // line request accepted, awaiting fill
      ENT_DRAIN = 2'd3    // fill received, answering requesters
   } ent_st_e;
endpackage

// File: rtl/mmb_lowest.sv
module mmb_lowest #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/mmb_sat_cnt.sv
module mmb_sat_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (clr)                  cnt <= '0;
      else if (inc && (cnt != '1))   cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/mmb_l2_arb.sv
module mmb_l2_arb #(
   parameter int NUM_ENT = 4,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_ENT-1:0] wait_vec,
   input  logic               st_valid,
   input  logic               l2_ready,
   output logic               miss_sel,
   output logic [IDX_W-1:0]   gnt_idx,
   output logic               l2_valid,
   output logic               st_ready
);
   // line requests always win over forwarded stores
   mmb_lowest #(.N(NUM_ENT), .IW(IDX_W)) u_pick (
      .vec (wait_vec),
      .idx (gnt_idx),
      .any (miss_sel)
   );
   assign l2_valid = miss_sel || st_valid;
   assign st_ready = !miss_sel && l2_ready;
endmodule

// File: rtl/mmb_entry.sv
module mmb_entry
   import mmb_pkg::*;
#(
   parameter int LINE_W    = 26,
   parameter int TAG_W     = 6,
   parameter int MRG_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic              merge,
   input  logic [LINE_W-1:0] line_in,
   input  logic [TAG_W-1:0]  tag_in,
   input  logic              issue_ack,
   input  logic              cancel,
   input  logic              fill,
   input  logic              rsp_grant,
   output ent_st_e           state,
   output logic [LINE_W-1:0] line,
   output logic [TAG_W-1:0]  head_tag,
   output logic              full
);
   localparam int CNT_MW = $clog2(MRG_DEPTH + 1);
   localparam int PTR_W  = $clog2(MRG_DEPTH);

   logic [TAG_W-1:0]  tags [MRG_DEPTH];
   logic [CNT_MW-1:0] cnt;
   logic [PTR_W-1:0]  rd;
   logic [CNT_MW-1:0] last_pos;

   assign last_pos = cnt - CNT_MW'(1);
   assign full     = (cnt == CNT_MW'(MRG_DEPTH));
   assign head_tag = tags[rd];

   // requester list, written in arrival order
   always_ff @(posedge clk) begin
      if (alloc)      tags[0] <= tag_in;
      else if (merge) tags[cnt[PTR_W-1:0]] <= tag_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ENT_FREE;
         line  <= '0;
         cnt   <= '0;
         rd    <= '0;
      end else begin
         unique case (state)
            ENT_FREE: begin
               if (alloc) begin
                  state <= ENT_WAIT;
                  line  <= line_in;
                  cnt   <= CNT_MW'(1);
                  rd    <= '0;
               end
            end
            ENT_WAIT: begin
               if (merge) cnt <= cnt + CNT_MW'(1);
               if (issue_ack)   state <= ENT_OUT;
               else if (cancel) state <= ENT_FREE;
            end
            ENT_OUT: begin
               if (merge) cnt <= cnt + CNT_MW'(1);
               if (fill) begin
                  state <= ENT_DRAIN;
                  rd    <= '0;
               end
            end
            ENT_DRAIN: begin
               if (rsp_grant) begin
                  if (CNT_MW'(rd) == last_pos) state <= ENT_FREE;
                  else                         rd    <= rd + PTR_W'(1);
               end
            end
            default: state <= ENT_FREE;
         endcase
      end
   end
endmodule

// File: rtl/miss_merge_buf.sv
module miss_merge_buf
   import mmb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int TAG_W      = 6,
   parameter int NUM_ENT    = 4,
   parameter int MRG_DEPTH  = 8,
   parameter int LINE_BYTES = 64,
   parameter int CNT_W      = 32,
   localparam int IDX_W     = $clog2(NUM_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   output logic              miss_ready,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic [TAG_W-1:0]  miss_tag,
   output logic [IDX_W-1:0]  miss_idx,
   input  logic              cancel_valid,
   input  logic [IDX_W-1:0]  cancel_idx,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   output logic              l2_req_valid,
   input  logic              l2_req_ready,
   output logic              l2_req_is_st,
   output logic [ADDR_W-1:0] l2_req_addr,
   output logic [DATA_W-1:0] l2_req_data,
   output logic [IDX_W-1:0]  l2_req_id,
   input  logic              fill_valid,
   input  logic [IDX_W-1:0]  fill_idx,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [IDX_W-1:0]  rsp_idx,
   input  logic              cnt_clear,
   output logic [CNT_W-1:0]  cnt_l1_miss,
   output logic [CNT_W-1:0]  cnt_l2_acc,
   output logic [CNT_W-1:0]  cnt_squash
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFF_W;

   // elaboration-time parameter checks
   if (NUM_ENT < 2)                        begin : g_bad_ent  $error("NUM_ENT must be at least 2"); end
   if (MRG_DEPTH < 2)                      begin : g_bad_mrg  $error("MRG_DEPTH must be at least 2"); end
   if ((1 << OFF_W) != LINE_BYTES)         begin : g_bad_line $error("LINE_BYTES must be a power of two"); end
   if (LINE_W < 1)                         begin : g_bad_addr $error("ADDR_W must exceed the line offset"); end
   if (CNT_W < 2)                          begin : g_bad_cnt  $error("CNT_W must be at least 2"); end

   logic [LINE_W-1:0] miss_line;
   logic [OFF_W-1:0]  unused_off;
   assign miss_line  = miss_addr[ADDR_W-1:OFF_W];
   assign unused_off = miss_addr[OFF_W-1:0];

   ent_st_e           est   [NUM_ENT];
   logic [LINE_W-1:0] eline [NUM_ENT];
   logic [TAG_W-1:0]  ehead [NUM_ENT];
   logic [NUM_ENT-1:0] efull, match_v, free_v, wait_v, drain_v;
   logic [NUM_ENT-1:0] alloc_v, merge_v, ack_v, cancel_v, fill_v, grant_v;

   logic [IDX_W-1:0] hit_idx, free_idx, drain_idx, gnt_idx;
   logic             hit_any, free_any, drain_any, miss_sel, accept;

   // entry array
   for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
      assign match_v[g]  = ((est[g] == ENT_WAIT) || (est[g] == ENT_OUT)) && (eline[g] == miss_line);
      assign free_v[g]   = (est[g] == ENT_FREE);
      assign wait_v[g]   = (est[g] == ENT_WAIT);
      assign drain_v[g]  = (est[g] == ENT_DRAIN);
      assign alloc_v[g]  = accept && !hit_any && (free_idx == IDX_W'(g));
      assign merge_v[g]  = accept &&  hit_any && (hit_idx  == IDX_W'(g));
      assign ack_v[g]    = miss_sel && l2_req_ready && (gnt_idx == IDX_W'(g));
      assign cancel_v[g] = cancel_valid && (cancel_idx == IDX_W'(g));
      assign fill_v[g]   = fill_valid && (fill_idx == IDX_W'(g));
      assign grant_v[g]  = drain_any && (drain_idx == IDX_W'(g));

      mmb_entry #(
         .LINE_W    (LINE_W),
         .TAG_W     (TAG_W),
         .MRG_DEPTH (MRG_DEPTH)
      ) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (alloc_v[g]),
         .merge     (merge_v[g]),
         .line_in   (miss_line),
         .tag_in    (miss_tag),
         .issue_ack (ack_v[g]),
         .cancel    (cancel_v[g]),
         .fill      (fill_v[g]),
         .rsp_grant (grant_v[g]),
         .state     (est[g]),
         .line      (eline[g]),
         .head_tag  (ehead[g]),
         .full      (efull[g])
      );
   end

   mmb_lowest #(.N(NUM_ENT), .IW(IDX_W)) u_hit   (.vec(match_v), .idx(hit_idx),   .any(hit_any));
   mmb_lowest #(.N(NUM_ENT), .IW(IDX_W)) u_free  (.vec(free_v),  .idx(free_idx),  .any(free_any));
   mmb_lowest #(.N(NUM_ENT), .IW(IDX_W)) u_drain (.vec(drain_v), .idx(drain_idx), .any(drain_any));

   // lookup and acceptance
   assign miss_ready = !cancel_valid && (hit_any ? !efull[hit_idx] : free_any);
   assign accept     = miss_valid && miss_ready;
   assign miss_idx   = hit_any ? hit_idx : free_idx;

   // shared downstream port
   mmb_l2_arb #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_arb (
      .wait_vec (wait_v),
      .st_valid (st_valid),
      .l2_ready (l2_req_ready),
      .miss_sel (miss_sel),
      .gnt_idx  (gnt_idx),
      .l2_valid (l2_req_valid),
      .st_ready (st_ready)
   );

   assign l2_req_is_st = !miss_sel;
   assign l2_req_addr  = miss_sel ? {eline[gnt_idx], {OFF_W{1'b0}}} : st_addr;
   assign l2_req_data  = miss_sel ? '0 : st_data;
   assign l2_req_id    = miss_sel ? gnt_idx : '0;

   // responses
   assign rsp_valid = drain_any;
   assign rsp_tag   = ehead[drain_idx];
   assign rsp_idx   = drain_idx;

   // event counters
   logic [2:0]       ev_inc;
   logic [CNT_W-1:0] ev_cnt [3];
   assign ev_inc[0] = accept;
   assign ev_inc[1] = l2_req_valid && l2_req_ready;
   assign ev_inc[2] = accept && hit_any;

   for (genvar c = 0; c < 3; c++) begin : g_cnt
      mmb_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (cnt_clear),
         .inc   (ev_inc[c]),
         .cnt   (ev_cnt[c])
      );
   end

   assign cnt_l1_miss = ev_cnt[0];
   assign cnt_l2_acc  = ev_cnt[1];
   assign cnt_squash  = ev_cnt[2];
endmodule

// File: rtl/mmb_checker.sv
module mmb_checker #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int CNT_W      = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              miss_valid,
   input logic              miss_ready,
   input logic              cancel_valid,
   input logic              st_valid,
   input logic              st_ready,
   input logic              l2_req_valid,
   input logic              l2_req_ready,
   input logic              l2_req_is_st,
   input logic [ADDR_W-1:0] l2_req_addr,
   input logic              cnt_clear,
   input logic [CNT_W-1:0]  cnt_l1_miss,
   input logic [CNT_W-1:0]  cnt_l2_acc,
   input logic [CNT_W-1:0]  cnt_squash
);
   localparam int OFF_W = $clog2(LINE_BYTES);

   assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_req_valid && !l2_req_is_st) |-> (l2_req_addr[OFF_W-1:0] == '0));

   assert_l1_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_clear && !(miss_valid && miss_ready)) |=> $stable(cnt_l1_miss));

   assert_l2_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_clear && !(l2_req_valid && l2_req_ready)) |=> $stable(cnt_l2_acc));

   assert_squash_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_squash <= cnt_l1_miss);

   assert_cancel_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_valid |-> !miss_ready);

   assert_miss_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_req_valid && !l2_req_is_st) |-> !st_ready);

   assert_store_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready) |-> (l2_req_valid && l2_req_is_st));

   assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_clear && (cnt_l1_miss == '1)) |=> (cnt_l1_miss == '1));

   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clear |=> ((cnt_l1_miss == '0) && (cnt_l2_acc == '0) && (cnt_squash == '0)));
endmodule

bind miss_merge_buf mmb_checker #(
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES),
   .CNT_W      (CNT_W)
) u_mmb_chk (.*);

// File: tb/miss_merge_buf_bench.sv
module miss_merge_buf_bench;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int TW = 6;
   localparam int NE = 4;
   localparam int MD = 64;
   localparam int CW = 7;
   localparam int IW = 2;
   localparam int OFF = 6;
   localparam longint MAXC = (64'd1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n;
   logic miss_valid, miss_ready;
   logic [AW-1:0] miss_addr;
   logic [TW-1:0] miss_tag;
   logic [IW-1:0] miss_idx;
   logic cancel_valid;
   logic [IW-1:0] cancel_idx;
   logic st_valid, st_ready;
   logic [AW-1:0] st_addr;
   logic [DW-1:0] st_data;
   logic l2_req_valid, l2_req_ready, l2_req_is_st;
   logic [AW-1:0] l2_req_addr;
   logic [DW-1:0] l2_req_data;
   logic [IW-1:0] l2_req_id;
   logic fill_valid;
   logic [IW-1:0] fill_idx;
   logic rsp_valid;
   logic [TW-1:0] rsp_tag;
   logic [IW-1:0] rsp_idx;
   logic cnt_clear;
   logic [CW-1:0] cnt_l1_miss, cnt_l2_acc, cnt_squash;

   always #5 clk = ~clk;

   miss_merge_buf #(
      .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .NUM_ENT(NE),
      .MRG_DEPTH(MD), .LINE_BYTES(64), .CNT_W(CW)
   ) u_miss_merge_buf (.*);

   // reference model state
   int     mst  [NE];   // 0 free, 1 waiting, 2 outstanding, 3 draining
   int     mline[NE];
   int     tq   [NE][$];
   longint c_l1, c_l2, c_sq;
   int     n_cmp = 0;
   int     n_bad = 0;
   bit     done  = 1'b0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic longint sat_inc(input longint v);
      return (v == MAXC) ? v : v + 1;
   endfunction

   // one clock: compare on settled inputs, then advance the model
   task automatic step();
      int h, f, w, d;
      bit rdy, acc, l2hs;
      #1;
      h = -1; f = -1; w = -1; d = -1;
      for (int i = 0; i < NE; i++) begin
         if (h < 0 && (mst[i] == 1 || mst[i] == 2) && mline[i] == int'(miss_addr >> OFF)) h = i;
         if (f < 0 && mst[i] == 0) f = i;
         if (w < 0 && mst[i] == 1) w = i;
         if (d < 0 && mst[i] == 3) d = i;
      end
      rdy = !cancel_valid && ((h >= 0) ? (tq[h].size() < MD) : (f >= 0));
      chk("R5", "miss_ready", miss_ready, rdy);
      if (miss_valid && rdy)
         chk((h >= 0) ? "R3" : "R2", "miss_idx", miss_idx, (h >= 0) ? h : f);
      chk("R8", "l2_req_valid", l2_req_valid, (w >= 0) || st_valid);
      if (w >= 0) begin
         chk("R2", "l2_req_is_st", l2_req_is_st, 0);
         chk("R1", "l2_req_addr", l2_req_addr, longint'(mline[w]) << OFF);
         chk("R2", "l2_req_id", l2_req_id, w);
      end else if (st_valid) begin
         chk("R8", "l2_req_is_st", l2_req_is_st, 1);
         chk("R8", "l2_req_addr", l2_req_addr, st_addr);
         chk("R8", "l2_req_data", l2_req_data, st_data);
      end
      chk("R8", "st_ready", st_ready, (w < 0) && l2_req_ready);
      chk("R6", "rsp_valid", rsp_valid, d >= 0);
      if (d >= 0) begin
         chk("R6", "rsp_tag", rsp_tag, tq[d][0]);
         chk("R6", "rsp_idx", rsp_idx, d);
      end
      chk("R4", "cnt_l1_miss", cnt_l1_miss, c_l1);
      chk("R4", "cnt_l2_acc", cnt_l2_acc, c_l2);
      chk("R4", "cnt_squash", cnt_squash, c_sq);
      acc  = miss_valid && rdy;
      l2hs = ((w >= 0) || st_valid) && l2_req_ready;
      @(posedge clk);
      if (cnt_clear) begin
         c_l1 = 0; c_l2 = 0; c_sq = 0;
      end else begin
         if (acc)            c_l1 = sat_inc(c_l1);
         if (acc && h >= 0)  c_sq = sat_inc(c_sq);
         if (l2hs)           c_l2 = sat_inc(c_l2);
      end
      if (fill_valid && mst[fill_idx] == 2) mst[fill_idx] = 3;
      if (cancel_valid && mst[cancel_idx] == 1 && !(w == int'(cancel_idx) && l2_req_ready)) begin
         mst[cancel_idx] = 0;
         tq[cancel_idx].delete();
      end
      if (w >= 0 && l2_req_ready) mst[w] = 2;
      if (d >= 0) begin
         void'(tq[d].pop_front());
         if (tq[d].size() == 0) mst[d] = 0;
      end
      if (acc) begin
         if (h >= 0) tq[h].push_back(int'(miss_tag));
         else begin
            mst[f]   = 1;
            mline[f] = int'(miss_addr >> OFF);
            tq[f].delete();
            tq[f].push_back(int'(miss_tag));
         end
      end
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      miss_valid = 0; cancel_valid = 0; st_valid = 0; fill_valid = 0; cnt_clear = 0;
   endtask

   task automatic put_miss(input int addr, input int tag);
      miss_valid = 1; miss_addr = AW'(addr); miss_tag = TW'(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NE; i++) begin mst[i] = 0; mline[i] = 0; end
      c_l1 = 0; c_l2 = 0; c_sq = 0;
      rst_n = 0; idle_inputs();
      miss_addr = '0; miss_tag = '0; cancel_idx = '0; st_addr = '0; st_data = '0;
      fill_idx = '0; l2_req_ready = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // reset state: ready, no traffic, counters zero (R4, R5)
      step(); step();

      // R1 R3 R4: 64 byte misses in one line merge into one entry
      for (int k = 0; k < 64; k++) begin put_miss('h1000 + k, k); step(); end
      put_miss('h1005, 9); step();            // R5: tag list full, not accepted
      put_miss('h1040, 33); step();           // R1: next line allocates entry 1
      idle_inputs();
      chk("R4", "64 misses l1 count", cnt_l1_miss, 65);
      chk("R3", "64 misses squash count", cnt_squash, 63);
      chk("R4", "no access while stalled", cnt_l2_acc, 0);
      // R8: store waits behind both line requests
      st_valid = 1; st_addr = 'h3456; st_data = 'hbeef; step();
      l2_req_ready = 1; step(); step(); step();
      st_valid = 0; step();
      chk("R4", "two lines and one store", cnt_l2_acc, 3);
      // R6/R7: fill entry 0, then fill entry 1 with a same-cycle merge
      fill_valid = 1; fill_idx = 0; step();
      fill_idx = 1; put_miss('h1047, 50); step();
      idle_inputs();
      for (int k = 0; k < 70; k++) step();
      chk("R7", "merged-on-fill squash", cnt_squash, 64);
      chk("R6", "all drained", rsp_valid, 0);

      // R5 R9: fill every entry, cancel one, back-pressure a fifth line
      l2_req_ready = 0;
      for (int k = 0; k < 4; k++) begin put_miss('h2000 + k * 64, k); step(); end
      put_miss('h2400, 20); step();           // R5: no free entry
      cancel_valid = 1; cancel_idx = 2; step(); // R9: frees waiting entry 2, miss blocked
      cancel_valid = 0; step();                // fifth line takes entry 2
      idle_inputs();
      l2_req_ready = 1;
      for (int k = 0; k < 4; k++) step();
      cancel_valid = 1; cancel_idx = 0; step(); // R9: outstanding entry, ignored
      cancel_valid = 0;
      fill_valid = 1; fill_idx = 3; step();
      fill_idx = 1; step();
      fill_idx = 0; step();
      fill_idx = 2; step();
      fill_idx = 2; step();                    // R6: not outstanding, ignored
      fill_valid = 0;
      for (int k = 0; k < 8; k++) step();

      // R10: clear, then random traffic until saturation
      cnt_clear = 1; step(); cnt_clear = 0;
      chk("R10", "cleared l1", cnt_l1_miss, 0);
      for (int c = 0; c < 4000; c++) begin
         miss_valid   = ($urandom % 3) != 0;
         miss_addr    = AW'('h4000 + ($urandom % 6) * 64 + ($urandom % 64));
         miss_tag     = TW'($urandom);
         l2_req_ready = ($urandom % 2) != 0;
         st_valid     = ($urandom % 4) == 0;
         st_addr      = AW'($urandom);
         st_data      = DW'($urandom);
         begin
            int e;
            e = int'($urandom % NE);
            fill_valid = (mst[e] == 2) && (($urandom % 2) != 0);
            fill_idx   = IW'(e);
            e = int'($urandom % NE);
            cancel_valid = (mst[e] == 1) && (($urandom % 8) == 0);
            cancel_idx   = IW'(e);
         end
         step();
      end
      idle_inputs();
      chk("R10", "l1 saturated", cnt_l1_miss, MAXC);
      chk("R10", "l2 saturated", cnt_l2_acc, MAXC);
      put_miss('h4000, 1); cnt_clear = 1; step();   // R10: clear beats increment
      idle_inputs(); step();
      chk("R10", "clear wins", cnt_l1_miss, 0);
      for (int k = 0; k < 600; k++) begin
         l2_req_ready = 1;
         begin
            int e;
            e = int'($urandom % NE);
            fill_valid = (mst[e] == 2);
            fill_idx   = IW'(e);
         end
         step();
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule